// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block is a small stack-machine datapath. It takes a stream of instructions on a valid/ready interface and applies each one to an internal operand stack. The instructions never name their operands. PUSH brings a value in from the instruction data port. POP sends the top value out on a result port. ADD, SUB, MUL and DIV each take the two uppermost entries and fold them into one result.

The operand order for a binary operation is the entry below the top, then the top. So pushing x, then y, then issuing SUB leaves x-y. A program of pushes, operations and a final pop can therefore evaluate a nested expression with no memory addressing at all. The block raises three sticky error flags: one for a push with no room left, one for too few operands, and one for a zero divisor. Only reset clears these flags.

Top module: `opstack_unit`

## Requirements
- R1: While rst_n is low, instr_ready, pop_valid and all three error flags are low. On the first clock after release, instr_ready goes high, and it stays high for as long as reset remains released.
- R2: The opcode is carried in instr_op: PUSH=3'd0, POP=3'd1. An accepted PUSH puts instr_data on top of the stack. An accepted POP on a non-empty stack removes the top entry. The cycle after the accepting edge, pop_valid is high for one cycle and pop_data holds that entry, in last-in, first-out order.
- R3: ADD=3'd2 and SUB=3'd3. Each replaces the top two entries with (entry below top) OP (top), wrapped to 16 bits, so the depth drops by one.
- R4: MUL=3'd4 replaces the top two entries with the low 16 bits of their signed product.
- R5: DIV=3'd5 replaces the top two entries with the signed quotient (entry below top)/(top), truncated toward zero and kept to 16 bits. For example, -32768/-1 gives -32768.
- R6: A DIV whose top entry is zero still folds the two entries into one, but the value written is 0. It also sets err_divzero, which then stays high until reset.
- R7: A binary operation issued with fewer than two entries, or a POP issued on an empty stack, leaves the stack unchanged. It raises no pop_valid and sets err_underflow, which stays high until reset.
- R8: The stack holds at most 8 entries. A PUSH issued on a full stack is discarded and sets err_overflow, which stays high until reset.
- R9: Opcodes 3'd6 and 3'd7 are accepted and have no effect on the stack or on the flags.
- R10: One instruction is accepted on every cycle in which instr_valid is high. A cycle with instr_valid low changes nothing.
- R11: The program PUSH A, PUSH B, SUB, PUSH C, PUSH D, PUSH E, MUL, ADD, DIV, POP returns (A-B)/(C+D*E).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_valid | input | 1 | An instruction is offered |
| instr_ready | output | 1 | The unit accepts instructions |
| instr_op | input | 3 | Opcode |
| instr_data | input | 16 | Value for PUSH |
| pop_valid | output | 1 | pop_data holds a popped value |
| pop_data | output | 16 | Popped value |
| err_overflow | output | 1 | Sticky: a PUSH was issued on a full stack |
| err_underflow | output | 1 | Sticky: an instruction was issued with too few entries |
| err_divzero | output | 1 | Sticky: a DIV was issued with a zero divisor |

## Verification
A zero divisor brings two functions into the same cycle: the error is detected, and the fold still writes back its forced zero result. The bench provokes this across a sweep of signed operand pairs that includes zero, extreme and negative values. It then checks both that the flag is set and that the value popped afterwards is 0. Push and overflow detection also meet at the ninth push. There the bench checks that the flag is raised and that the eight values popped afterwards are exactly the eight that were pushed.

// File: rtl/opstack_pkg.sv
package opstack_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  function automatic logic is_binary(input op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
  endfunction
endpackage

// File: rtl/opstack_alu.sv
module opstack_alu
  import opstack_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e                 op,
  input  logic signed [W-1:0] lhs,
  input  logic signed [W-1:0] rhs,
  output logic        [W-1:0] res,
  output logic                div_zero
);
  always_comb begin
    div_zero = (op == OP_DIV) && (rhs == '0);
    unique case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = lhs * rhs;
      OP_DIV: begin
        if (rhs == '0) res = '0;
        else res = W'($signed({lhs[W-1], lhs}) / $signed({rhs[W-1], rhs}));
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/opstack_mem.sv
module opstack_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic             pop_en,
  input  logic             fold_en,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     top,
  output logic [W-1:0]     second,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     ent [DEPTH];
  logic [CNT_W-1:0] count_d;
  logic [DEPTH-1:0] wr_en;
  logic [IDX_W-1:0] top_idx, sec_idx;

  assign top_idx = IDX_W'(count - CNT_W'(1));
  assign sec_idx = IDX_W'(count - CNT_W'(2));
  assign top     = ent[top_idx];
  assign second  = ent[sec_idx];

  always_comb begin
    count_d = count;
    if (push_en)                count_d = count + CNT_W'(1);
    else if (pop_en || fold_en) count_d = count - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign wr_en[i] = (push_en && count == CNT_W'(i)) ||
                      (fold_en && count == CNT_W'(i + 2));
    always_ff @(posedge clk) begin
      if (wr_en[i]) ent[i] <= wdata;
    end
  end

  // R8: depth never exceeds capacity
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R10: at most one stack action per cycle
  a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_en, pop_en, fold_en}));
  // R2: a push grows the stack by one
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> count == $past(count) + CNT_W'(1));
endmodule

// File: rtl/opstack_unit.sv
module opstack_unit
  import opstack_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instr_valid,
  output logic         instr_ready,
  input  logic [2:0]   instr_op,
  input  logic [W-1:0] instr_data,
  output logic         pop_valid,
  output logic [W-1:0] pop_data,
  output logic         err_overflow,
  output logic         err_underflow,
  output logic         err_divzero
);
  op_e              op;
  logic             fire, bin, full, empty, short;
  logic             push_en, pop_en, fold_en, ovf_ev, ufl_ev;
  logic [W-1:0]     top, second, alu_res, wdata;
  logic             alu_dz;
  logic [CNT_W-1:0] count;

  logic         rdy_q, pv_q, ovf_q, ufl_q, dz_q;
  logic         pv_d, ovf_d, ufl_d, dz_d;
  logic [W-1:0] pd_q;

  assign op    = op_e'(instr_op);
  assign fire  = instr_valid && rdy_q;
  assign bin   = is_binary(op);
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign short = (count < CNT_W'(2));

  assign push_en = fire && op == OP_PUSH && !full;
  assign pop_en  = fire && op == OP_POP && !empty;
  assign fold_en = fire && bin && !short;
  assign ovf_ev  = fire && op == OP_PUSH && full;
  assign ufl_ev  = fire && ((op == OP_POP && empty) || (bin && short));
  assign wdata   = push_en ? instr_data : alu_res;

  opstack_alu #(.W(W)) u_alu (
    .op(op), .lhs(second), .rhs(top), .res(alu_res), .div_zero(alu_dz)
  );

  opstack_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_en(pop_en),
    .fold_en(fold_en), .wdata(wdata), .top(top), .second(second), .count(count)
  );

  always_comb begin
    pv_d  = pop_en;
    ovf_d = ovf_q || ovf_ev;
    ufl_d = ufl_q || ufl_ev;
    dz_d  = dz_q || (fold_en && alu_dz);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      pv_q  <= 1'b0;
      ovf_q <= 1'b0;
      ufl_q <= 1'b0;
      dz_q  <= 1'b0;
      pd_q  <= '0;
    end else begin
      rdy_q <= 1'b1;
      pv_q  <= pv_d;
      ovf_q <= ovf_d;
      ufl_q <= ufl_d;
      dz_q  <= dz_d;
      if (pop_en) pd_q <= top;
    end
  end

  assign instr_ready   = rdy_q;
  assign pop_valid     = pv_q;
  assign pop_data      = pd_q;
  assign err_overflow  = ovf_q;
  assign err_underflow = ufl_q;
  assign err_divzero   = dz_q;

  // R1: ready stays high once raised
  a_r1_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready |=> instr_ready);
  // R2: a popped value only follows an accepted POP on a non-empty stack
  a_r2_pop_source: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> ($past(fire) && $past(instr_op) == OP_POP && $past(count) != '0));
  // R6: zero divisor flags and still collapses two entries into one
  a_r6_divzero_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_DIV && !short && top == '0) |=>
      (err_divzero && count == $past(count) - CNT_W'(1)));
  // R7: a short binary operation leaves the depth alone and flags
  a_r7_underflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bin && short) |=> (err_underflow && $stable(count)));
  // R7: underflow is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);
  // R8: push on a full stack flags and keeps the depth
  a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_PUSH && full) |=> (err_overflow && count == CNT_W'(DEPTH)));
endmodule

// File: tb/opstack_unit_tb.sv
module opstack_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic        instr_ready;
  logic [2:0]  instr_op;
  logic [15:0] instr_data;
  logic        pop_valid;
  logic [15:0] pop_data;
  logic        err_overflow, err_underflow, err_divzero;

  int n_chk = 0;
  int n_fail = 0;
  logic s_pv;
  int   s_pd;

  always #10 clk = ~clk;

  opstack_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_data(instr_data), .pop_valid(pop_valid),
    .pop_data(pop_data), .err_overflow(err_overflow), .err_underflow(err_underflow),
    .err_divzero(err_divzero)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int d);
    instr_valid = 1'b1;
    instr_op    = op;
    instr_data  = d[15:0];
    @(negedge clk);
    s_pv = pop_valid;
    s_pd = int'($signed(pop_data));
  endtask

  task automatic idle();
    instr_valid = 1'b0;
    instr_op    = 3'd0;
    instr_data  = 16'h5a5a;
    @(negedge clk);
    s_pv = pop_valid;
  endtask

  task automatic do_reset(input bit chk_it);
    rst_n = 1'b0;
    instr_valid = 1'b0;
    repeat (2) @(negedge clk);
    if (chk_it) check(!instr_ready && !pop_valid, "R1 ready low in reset", int'(instr_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    if (chk_it) begin
      check(instr_ready, "R1 ready after reset", int'(instr_ready), 1);
      check({err_overflow, err_underflow, err_divzero} == 3'b000, "R1 flags clear",
            int'({err_overflow, err_underflow, err_divzero}), 0);
    end
  endtask

  function automatic int wrap16(input int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int model(input int op, input int a, input int b);
    case (op)
      2: return wrap16(a + b);
      3: return wrap16(a - b);
      4: return wrap16(a * b);
      default: return (b == 0) ? 0 : wrap16(a / b);
    endcase
  endfunction

  task automatic pop_expect(input string tag, input int exp);
    issue(3'd1, 0);
    check(s_pv == 1'b1, {tag, " pop_valid"}, int'(s_pv), 1);
    check(s_pd == exp, tag, s_pd, exp);
  endtask

  task automatic expr(input int a, input int b, input int c, input int d, input int e);
    int exp;
    exp = (a - b) / (c + d * e);
    issue(3'd0, a); issue(3'd0, b); issue(3'd3, 0);
    issue(3'd0, c); issue(3'd0, d); issue(3'd0, e);
    issue(3'd4, 0); issue(3'd2, 0); issue(3'd5, 0);
    pop_expect("R11 expression", exp);
    idle();
  endtask

  int vals[11] = '{0, 1, -1, 2, -2, 7, -7, 32767, -32768, 100, -300};

  initial begin
    instr_valid = 1'b0; instr_op = 3'd0; instr_data = '0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset(1'b1);

    // R3 R4 R5 R6: operand sweep, back-to-back instructions
    for (int op = 2; op <= 5; op++) begin
      for (int i = 0; i < 11; i++) begin
        for (int j = 0; j < 11; j++) begin
          issue(3'd0, vals[i]);
          issue(3'd0, vals[j]);
          issue(3'(op), 0);
          check(s_pv == 1'b0, "R3 no pop on fold", int'(s_pv), 0);
          pop_expect($sformatf("R3/R4/R5/R6 op%0d %0d,%0d", op, vals[i], vals[j]),
                     model(op, vals[i], vals[j]));
          if (op == 5 && vals[j] == 0) begin
            check(err_divzero, "R6 divzero flag", int'(err_divzero), 1);
            idle();
            check(err_divzero, "R6 divzero sticky", int'(err_divzero), 1);
            do_reset(1'b0);
          end else begin
            check(!err_divzero && !err_underflow, "R3 no spurious flag",
                  int'({err_divzero, err_underflow}), 0);
          end
        end
      end
    end
    idle();
    check(!pop_valid, "R2 pop_valid one cycle", int'(pop_valid), 0);

    // R5: extreme quotient
    issue(3'd0, -32768); issue(3'd0, -1); issue(3'd5, 0);
    pop_expect("R5 min/-1", -32768);

    // R7: underflow on short fold and empty pop
    do_reset(1'b0);
    issue(3'd0, 5);
    issue(3'd2, 0);
    check(err_underflow, "R7 fold underflow flag", int'(err_underflow), 1);
    pop_expect("R7 stack unchanged", 5);
    issue(3'd1, 0);
    check(!s_pv, "R7 empty pop no valid", int'(s_pv), 0);
    idle();
    check(err_underflow && !err_overflow, "R7 sticky", int'(err_underflow), 1);

    // R8: overflow
    do_reset(1'b0);
    for (int k = 1; k <= 8; k++) issue(3'd0, k * 11);
    check(!err_overflow, "R8 full no flag", int'(err_overflow), 0);
    issue(3'd0, 999);
    check(err_overflow, "R8 overflow flag", int'(err_overflow), 1);
    for (int k = 8; k >= 1; k--) pop_expect("R8 LIFO after drop", k * 11);
    issue(3'd1, 0);
    check(!s_pv, "R8 nothing left", int'(s_pv), 0);

    // R9 R10: reserved opcodes and idle cycles
    do_reset(1'b0);
    issue(3'd0, 42);
    issue(3'd6, 7);
    issue(3'd7, 8);
    instr_valid = 1'b0; instr_op = 3'd0; instr_data = 16'd77;
    @(negedge clk);
    check({err_overflow, err_underflow, err_divzero} == 3'b000, "R9 no flags",
          int'({err_overflow, err_underflow, err_divzero}), 0);
    pop_expect("R9/R10 top intact", 42);
    issue(3'd1, 0);
    check(!s_pv, "R10 valid-low push ignored", int'(s_pv), 0);

    // R11: expression evaluation
    do_reset(1'b0);
    expr(50, 8, 3, 2, 5);
    expr(-100, 23, 1, -2, 3);
    check(instr_ready, "R10 ready held", int'(instr_ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule